// File: doc/BRIEF.md
# UART interrupt status and timeout unit

This block collects the interrupt-worthy conditions of one UART channel into an eight-bit status vector and drives a single interrupt request line. Each status bit has a mask bit, and the request is raised while any status bit and its mask bit are both high. The receiver, the transmitter, the modem-control logic and the autobaud measurement circuit report events through one-cycle strobes. The processor bus reports which accesses occurred through decoded strobes: receive buffer read, transmit buffer write and command write. Each sticky bit is set by its own event and cleared by its own kind of access.

The block also measures receive inactivity. It counts bit-time ticks while the receive FIFO holds unread data below its fullness threshold. When 64 ticks pass with no new character, it raises a receive-timeout flag. It also keeps the 16-bit baud divider. The processor loads the divider as two bytes, and the autobaud circuit loads it as one 16-bit value. The serial shifters, the FIFOs, the bus decoder and the autobaud measurement are outside the block.

Top module: `uis_top`

## Requirements
- R1: `statusOut` bit 0 follows `txHoldEmpty` in the same cycle. Bit 1 follows `rxFifoFull` when `fullSelMode` is 1, and follows (`rxLevel` != 0) when `fullSelMode` is 0.
- R2: `txLoad` is high for a cycle in which `busWrTxBuf` is high and `txHoldEmpty` is high. A write while `txHoldEmpty` is low produces no `txLoad`, so the character is discarded.
- R3: Status bit 4 (receive FIFO status) is set one cycle after `rxFifoEvt`. It stays set until a cycle with `busRdRxBuf`.
- R4: Status bit 5 (transmit FIFO status) is set one cycle after `txFifoEvt`. It stays set until a cycle with `busWrTxBuf`.
- R5: Status bit 2 (delta break) is set after `breakEdge`. It is cleared only by a command write (`busWrCmd`) with `cmdBrkRst` high.
- R6: `autobaudDone` loads `autobaudRate` into `divisorOut` and sets status bit 6. Bit 6 is cleared only by a command write with `cmdEnab` high. Other command writes leave it set.
- R7: Status bit 7 (change of state) is set by `ctsEdge` only while `ctsIrqEn` is high. It is cleared by a command write with `cmdCosRst` high.
- R8: Status bit 3 (receive timeout) is set on the 64th `bitTick` in which the FIFO is eligible. The FIFO is eligible when `rxEnable` is 1, `rxLevel` is not 0 and `rxLevel` < `rxThreshold`. No tick counts while `rxLevel` >= `rxThreshold`.
- R9: Status bit 3 is cleared, and the tick count restarts from zero, when a character arrives (`rxCharIn`), when `rxLevel` is 0 or when `rxEnable` is 0.
- R10: `wrDivHi` loads `wrData` into divider bits 15:8 and `wrDivLo` loads `wrData` into bits 7:0. Both bytes reset to zero.
- R11: `wrMask` loads `wrData` into the mask. The mask resets to zero. `irq` is high exactly when some bit of `statusOut` AND `maskOut` is 1.
- R12: When a set event and a clearing access fall in the same cycle, the sticky bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| rxThreshold | input | LVL_W | Receive FIFO fullness threshold |
| rxFifoFull | input | 1 | Receive FIFO is full |
| rxEnable | input | 1 | Receiver enabled |
| rxCharIn | input | 1 | A character entered the receive FIFO |
| rxFifoEvt | input | 1 | Programmed receiver FIFO condition changed |
| breakEdge | input | 1 | Start or end of a break was detected |
| txHoldEmpty | input | 1 | Transmit holding register is empty |
| txFifoEvt | input | 1 | Programmed transmitter FIFO condition changed |
| ctsEdge | input | 1 | CTS input changed level |
| ctsIrqEn | input | 1 | CTS changes may raise an interrupt |
| autobaudDone | input | 1 | Autobaud measurement finished |
| autobaudRate | input | 16 | Measured divider value |
| bitTick | input | 1 | One pulse per bit time |
| fullSelMode | input | 1 | Status bit 1 reports FIFO full (1) or receiver ready (0) |
| busRdRxBuf | input | 1 | Bus read of the receive buffer |
| busWrTxBuf | input | 1 | Bus write of the transmit buffer |
| busWrCmd | input | 1 | Bus write of the command register |
| cmdEnab | input | 1 | Command write touches the enable field |
| cmdBrkRst | input | 1 | Command write resets the break-change flag |
| cmdCosRst | input | 1 | Command write resets the change-of-state flag |
| wrData | input | 8 | Bus write data |
| wrMask | input | 1 | Write the mask register |
| wrDivHi | input | 1 | Write the upper divider byte |
| wrDivLo | input | 1 | Write the lower divider byte |
| statusOut | output | 8 | Status vector |
| maskOut | output | 8 | Mask register |
| divisorOut | output | 16 | Baud divider |
| irq | output | 1 | Interrupt request |
| txLoad | output | 1 | Transmit write accepted into the holding register |

## Verification
The situation hardest to reach from the ports is the timeout boundary. The flag must stay low after 63 eligible ticks and rise on the 64th, and a character arriving mid-count must restart the count from zero. The bench produces one tick every other cycle under a steady eligible FIFO level. It checks the flag after tick 63 and after tick 64. It then repeats the count after an arriving character and checks that 63 more ticks still leave the flag low. It also holds the level at the threshold for more than 64 ticks to show that no ticks are counted there.

// File: rtl/uis_pkg.sv
package uis_pkg;
  localparam int STAT_W = 8;

  localparam int BIT_TXRDY = 0;
  localparam int BIT_RXRDY = 1;
  localparam int BIT_BRK   = 2;
  localparam int BIT_TO    = 3;
  localparam int BIT_RXF   = 4;
  localparam int BIT_TXF   = 5;
  localparam int BIT_AB    = 6;
  localparam int BIT_COS   = 7;

  typedef struct packed {
    logic setRxFifo;
    logic clrRxFifo;
    logic setTxFifo;
    logic clrTxFifo;
    logic setBreak;
    logic clrBreak;
    logic setAb;
    logic clrAb;
    logic setCos;
    logic clrCos;
    logic setTo;
    logic clrTo;
    logic ldMask;
    logic ldDivHi;
    logic ldDivLo;
    logic ldDivAll;
  } strobe_t;
endpackage

// File: rtl/uis_ctrl.sv
module uis_ctrl
  import uis_pkg::*;
#(
  parameter int LVL_W    = 6,
  parameter int TO_TICKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxThreshold,
  input  logic             rxEnable,
  input  logic             rxCharIn,
  input  logic             rxFifoEvt,
  input  logic             breakEdge,
  input  logic             txHoldEmpty,
  input  logic             txFifoEvt,
  input  logic             ctsEdge,
  input  logic             ctsIrqEn,
  input  logic             autobaudDone,
  input  logic             bitTick,
  input  logic             busRdRxBuf,
  input  logic             busWrTxBuf,
  input  logic             busWrCmd,
  input  logic             cmdEnab,
  input  logic             cmdBrkRst,
  input  logic             cmdCosRst,
  input  logic             wrMask,
  input  logic             wrDivHi,
  input  logic             wrDivLo,
  output strobe_t          stb,
  output logic             txLoad
);
  localparam int CW = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);

  logic [CW-1:0] toCnt;
  logic          restart;
  logic          eligible;
  logic          lastTick;

  // Timeout restart conditions: arrival, drained FIFO, receiver off
  assign restart  = rxCharIn || (rxLevel == '0) || !rxEnable;
  assign eligible = !restart && (rxLevel < rxThreshold);
  assign lastTick = eligible && bitTick && (toCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (!eligible) begin
      toCnt <= '0;
    end else if (bitTick && (toCnt != LAST)) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  always_comb begin
    stb           = '0;
    stb.setRxFifo = rxFifoEvt;
    stb.clrRxFifo = busRdRxBuf;
    stb.setTxFifo = txFifoEvt;
    stb.clrTxFifo = busWrTxBuf;
    stb.setBreak  = breakEdge;
    stb.clrBreak  = busWrCmd && cmdBrkRst;
    stb.setAb     = autobaudDone;
    stb.clrAb     = busWrCmd && cmdEnab;
    stb.setCos    = ctsEdge && ctsIrqEn;
    stb.clrCos    = busWrCmd && cmdCosRst;
    stb.setTo     = lastTick;
    stb.clrTo     = restart;
    stb.ldMask    = wrMask;
    stb.ldDivHi   = wrDivHi;
    stb.ldDivLo   = wrDivLo;
    stb.ldDivAll  = autobaudDone;
  end

  assign txLoad = busWrTxBuf && txHoldEmpty;

  // R9: an arriving character restarts the inactivity count
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    rxCharIn |=> (toCnt == '0));

  // R2: nothing is accepted while the holding register is full
  a_r2_discard: assert property (@(posedge clk) disable iff (!rstN)
    !txHoldEmpty |-> !txLoad);

  // R8: the count never moves while the level is at or above the threshold
  a_r8_no_count_full: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel >= rxThreshold) |=> (toCnt == '0));
endmodule

// File: rtl/uis_datapath.sv
module uis_datapath
  import uis_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [2*BYTE_W-1:0] autobaudRate,
  input  logic                txHoldEmpty,
  input  logic                rxNotEmpty,
  input  logic                rxFifoFull,
  input  logic                fullSelMode,
  output logic [STAT_W-1:0]   statusOut,
  output logic [STAT_W-1:0]   maskOut,
  output logic [2*BYTE_W-1:0] divisorOut,
  output logic                irq
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [STAT_W-1:2] setVec;
  logic [STAT_W-1:2] clrVec;
  logic [STAT_W-1:2] stickyQ;
  logic [STAT_W-1:0] maskQ;
  logic [DIV_W-1:0]  divQ;

  always_comb begin
    setVec          = '0;
    clrVec          = '0;
    setVec[BIT_BRK] = stb.setBreak;  clrVec[BIT_BRK] = stb.clrBreak;
    setVec[BIT_TO]  = stb.setTo;     clrVec[BIT_TO]  = stb.clrTo;
    setVec[BIT_RXF] = stb.setRxFifo; clrVec[BIT_RXF] = stb.clrRxFifo;
    setVec[BIT_TXF] = stb.setTxFifo; clrVec[BIT_TXF] = stb.clrTxFifo;
    setVec[BIT_AB]  = stb.setAb;     clrVec[BIT_AB]  = stb.clrAb;
    setVec[BIT_COS] = stb.setCos;    clrVec[BIT_COS] = stb.clrCos;
  end

  // One sticky flag per status position; set takes priority over clear
  for (genvar i = 2; i < STAT_W; i++) begin : gSticky
    always_ff @(posedge clk) begin
      if (!rstN)          stickyQ[i] <= 1'b0;
      else if (setVec[i]) stickyQ[i] <= 1'b1;
      else if (clrVec[i]) stickyQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.ldMask) maskQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ <= '0;
    end else if (stb.ldDivAll) begin
      divQ <= autobaudRate;
    end else begin
      if (stb.ldDivHi) divQ[DIV_W-1:BYTE_W] <= wrData;
      if (stb.ldDivLo) divQ[BYTE_W-1:0]     <= wrData;
    end
  end

  assign statusOut  = {stickyQ,
                       fullSelMode ? rxFifoFull : rxNotEmpty,
                       txHoldEmpty};
  assign maskOut    = maskQ;
  assign divisorOut = divQ;
  assign irq        = |(statusOut & maskQ);

  // R12: a set event is never lost to a simultaneous clear
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setRxFifo && stb.clrRxFifo) |=> stickyQ[BIT_RXF]);

  // R6: autobaud flag leaves the set state only through its own clear
  a_r6_ab_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stickyQ[BIT_AB] && !stb.clrAb) |=> stickyQ[BIT_AB]);

  // R11: a mask write stores the bus byte
  a_r11_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldMask |=> (maskQ == $past(wrData)));

  // R10: a byte write leaves the other divider byte untouched
  a_r10_hi_only: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldDivHi && !stb.ldDivLo && !stb.ldDivAll)
      |=> (divQ[BYTE_W-1:0] == $past(divQ[BYTE_W-1:0])));
endmodule

// File: rtl/uis_top.sv
module uis_top
  import uis_pkg::*;
#(
  parameter int LVL_W    = 6,
  parameter int TO_TICKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxThreshold,
  input  logic             rxFifoFull,
  input  logic             rxEnable,
  input  logic             rxCharIn,
  input  logic             rxFifoEvt,
  input  logic             breakEdge,
  input  logic             txHoldEmpty,
  input  logic             txFifoEvt,
  input  logic             ctsEdge,
  input  logic             ctsIrqEn,
  input  logic             autobaudDone,
  input  logic [15:0]      autobaudRate,
  input  logic             bitTick,
  input  logic             fullSelMode,
  input  logic             busRdRxBuf,
  input  logic             busWrTxBuf,
  input  logic             busWrCmd,
  input  logic             cmdEnab,
  input  logic             cmdBrkRst,
  input  logic             cmdCosRst,
  input  logic [7:0]       wrData,
  input  logic             wrMask,
  input  logic             wrDivHi,
  input  logic             wrDivLo,
  output logic [7:0]       statusOut,
  output logic [7:0]       maskOut,
  output logic [15:0]      divisorOut,
  output logic             irq,
  output logic             txLoad
);
  strobe_t stb;

  uis_ctrl #(.LVL_W(LVL_W), .TO_TICKS(TO_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .rxLevel(rxLevel), .rxThreshold(rxThreshold),
    .rxEnable(rxEnable), .rxCharIn(rxCharIn), .rxFifoEvt(rxFifoEvt),
    .breakEdge(breakEdge), .txHoldEmpty(txHoldEmpty), .txFifoEvt(txFifoEvt),
    .ctsEdge(ctsEdge), .ctsIrqEn(ctsIrqEn), .autobaudDone(autobaudDone),
    .bitTick(bitTick), .busRdRxBuf(busRdRxBuf), .busWrTxBuf(busWrTxBuf),
    .busWrCmd(busWrCmd), .cmdEnab(cmdEnab), .cmdBrkRst(cmdBrkRst),
    .cmdCosRst(cmdCosRst), .wrMask(wrMask), .wrDivHi(wrDivHi),
    .wrDivLo(wrDivLo), .stb(stb), .txLoad(txLoad)
  );

  uis_datapath #(.BYTE_W(8)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrData(wrData), .autobaudRate(autobaudRate),
    .txHoldEmpty(txHoldEmpty), .rxNotEmpty(rxLevel != '0),
    .rxFifoFull(rxFifoFull), .fullSelMode(fullSelMode),
    .statusOut(statusOut), .maskOut(maskOut),
    .divisorOut(divisorOut), .irq(irq)
  );

  // R7: a CTS change with its interrupt disabled leaves the flag clear
  a_r7_cos_gate: assert property (@(posedge clk) disable iff (!rstN)
    (ctsEdge && !ctsIrqEn && !statusOut[BIT_COS]) |=> !statusOut[BIT_COS]);

  // R9: a disabled receiver drops the timeout flag
  a_r9_rx_off: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !autobaudDone) |=> !statusOut[BIT_TO]);
endmodule

// File: tb/tb_uis_top.sv
module tb_uis_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] rxLevel, rxThreshold;
  logic       rxFifoFull, rxEnable, rxCharIn, rxFifoEvt, breakEdge;
  logic       txHoldEmpty, txFifoEvt, ctsEdge, ctsIrqEn, autobaudDone;
  logic [15:0] autobaudRate;
  logic       bitTick, fullSelMode, busRdRxBuf, busWrTxBuf, busWrCmd;
  logic       cmdEnab, cmdBrkRst, cmdCosRst;
  logic [7:0] wrData;
  logic       wrMask, wrDivHi, wrDivLo;
  logic [7:0] statusOut, maskOut;
  logic [15:0] divisorOut;
  logic       irq, txLoad;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  uis_top dut (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .rxThreshold(rxThreshold),
    .rxFifoFull(rxFifoFull), .rxEnable(rxEnable), .rxCharIn(rxCharIn),
    .rxFifoEvt(rxFifoEvt), .breakEdge(breakEdge), .txHoldEmpty(txHoldEmpty),
    .txFifoEvt(txFifoEvt), .ctsEdge(ctsEdge), .ctsIrqEn(ctsIrqEn),
    .autobaudDone(autobaudDone), .autobaudRate(autobaudRate),
    .bitTick(bitTick), .fullSelMode(fullSelMode), .busRdRxBuf(busRdRxBuf),
    .busWrTxBuf(busWrTxBuf), .busWrCmd(busWrCmd), .cmdEnab(cmdEnab),
    .cmdBrkRst(cmdBrkRst), .cmdCosRst(cmdCosRst), .wrData(wrData),
    .wrMask(wrMask), .wrDivHi(wrDivHi), .wrDivLo(wrDivLo),
    .statusOut(statusOut), .maskOut(maskOut), .divisorOut(divisorOut),
    .irq(irq), .txLoad(txLoad)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idleAll();
    rxFifoFull = 0; rxCharIn = 0; rxFifoEvt = 0; breakEdge = 0;
    txFifoEvt = 0; ctsEdge = 0; ctsIrqEn = 0; autobaudDone = 0;
    autobaudRate = '0; bitTick = 0; fullSelMode = 0; busRdRxBuf = 0;
    busWrTxBuf = 0; busWrCmd = 0; cmdEnab = 0; cmdBrkRst = 0; cmdCosRst = 0;
    wrData = '0; wrMask = 0; wrDivHi = 0; wrDivLo = 0;
  endtask

  task automatic testReset();
    rstN = 0; idleAll(); txHoldEmpty = 0; rxLevel = 0; rxThreshold = 6'd4;
    rxEnable = 0;
    repeat (3) step();
    check("R11 reset mask", 32'(maskOut), 32'h0);
    check("R10 reset divisor", 32'(divisorOut), 32'h0);
    check("R11 reset irq", 32'(irq), 32'h0);
    rstN = 1; step();
    check("R1 reset status", 32'(statusOut), 32'h0);
  endtask

  task automatic testLive();
    txHoldEmpty = 1; #0;
    #1 check("R1 txrdy live", 32'(statusOut[0]), 32'h1);
    rxLevel = 6'd1; fullSelMode = 0; rxFifoFull = 0;
    #1 check("R1 rxrdy mode", 32'(statusOut[1]), 32'h1);
    fullSelMode = 1;
    #1 check("R1 full mode not full", 32'(statusOut[1]), 32'h0);
    rxFifoFull = 1;
    #1 check("R1 full mode full", 32'(statusOut[1]), 32'h1);
    rxFifoFull = 0; fullSelMode = 0; rxLevel = 0;
    step();
  endtask

  task automatic testTxLoad();
    txHoldEmpty = 0; busWrTxBuf = 1;
    #1 check("R2 discarded write", 32'(txLoad), 32'h0);
    txHoldEmpty = 1;
    #1 check("R2 accepted write", 32'(txLoad), 32'h1);
    busWrTxBuf = 0; step();
  endtask

  task automatic testRxTxFifo();
    rxFifoEvt = 1; step(); rxFifoEvt = 0;
    check("R3 rx fifo set", 32'(statusOut[4]), 32'h1);
    busWrTxBuf = 1; step(); busWrTxBuf = 0;
    check("R3 rx fifo kept on tx write", 32'(statusOut[4]), 32'h1);
    busRdRxBuf = 1; step(); busRdRxBuf = 0;
    check("R3 rx fifo cleared by read", 32'(statusOut[4]), 32'h0);
    txFifoEvt = 1; step(); txFifoEvt = 0;
    check("R4 tx fifo set", 32'(statusOut[5]), 32'h1);
    busRdRxBuf = 1; step(); busRdRxBuf = 0;
    check("R4 tx fifo kept on rx read", 32'(statusOut[5]), 32'h1);
    busWrTxBuf = 1; step(); busWrTxBuf = 0;
    check("R4 tx fifo cleared by write", 32'(statusOut[5]), 32'h0);
  endtask

  task automatic testSetWins();
    rxFifoEvt = 1; busRdRxBuf = 1; step(); rxFifoEvt = 0; busRdRxBuf = 0;
    check("R12 rx set wins", 32'(statusOut[4]), 32'h1);
    txFifoEvt = 1; busWrTxBuf = 1; step(); txFifoEvt = 0; busWrTxBuf = 0;
    check("R12 tx set wins", 32'(statusOut[5]), 32'h1);
    busRdRxBuf = 1; busWrTxBuf = 1; step(); busRdRxBuf = 0; busWrTxBuf = 0;
  endtask

  task automatic testBreakCos();
    breakEdge = 1; step(); breakEdge = 0;
    check("R5 break set", 32'(statusOut[2]), 32'h1);
    busWrCmd = 1; cmdEnab = 1; step(); busWrCmd = 0; cmdEnab = 0;
    check("R5 break kept", 32'(statusOut[2]), 32'h1);
    busWrCmd = 1; cmdBrkRst = 1; step(); busWrCmd = 0; cmdBrkRst = 0;
    check("R5 break cleared", 32'(statusOut[2]), 32'h0);
    ctsIrqEn = 0; ctsEdge = 1; step(); ctsEdge = 0;
    check("R7 cos gated off", 32'(statusOut[7]), 32'h0);
    ctsIrqEn = 1; ctsEdge = 1; step(); ctsEdge = 0;
    check("R7 cos set", 32'(statusOut[7]), 32'h1);
    busWrCmd = 1; cmdCosRst = 1; step(); busWrCmd = 0; cmdCosRst = 0;
    check("R7 cos cleared", 32'(statusOut[7]), 32'h0);
    ctsIrqEn = 0;
  endtask

  task automatic testDivAutobaud();
    wrData = 8'h3C; wrDivHi = 1; step(); wrDivHi = 0;
    check("R10 upper byte", 32'(divisorOut), 32'h3C00);
    wrData = 8'h81; wrDivLo = 1; step(); wrDivLo = 0;
    check("R10 lower byte", 32'(divisorOut), 32'h3C81);
    autobaudRate = 16'hA5C3; autobaudDone = 1; step(); autobaudDone = 0;
    check("R6 divisor loaded", 32'(divisorOut), 32'hA5C3);
    check("R6 autobaud set", 32'(statusOut[6]), 32'h1);
    busWrCmd = 1; cmdBrkRst = 1; cmdCosRst = 1; step();
    busWrCmd = 0; cmdBrkRst = 0; cmdCosRst = 0;
    check("R6 autobaud kept", 32'(statusOut[6]), 32'h1);
    busWrCmd = 1; cmdEnab = 1; step(); busWrCmd = 0; cmdEnab = 0;
    check("R6 autobaud cleared", 32'(statusOut[6]), 32'h0);
  endtask

  task automatic testMaskIrq();
    wrData = 8'h04; wrMask = 1; step(); wrMask = 0;
    check("R11 mask written", 32'(maskOut), 32'h04);
    check("R11 irq idle", 32'(irq), 32'h0);
    breakEdge = 1; step(); breakEdge = 0;
    check("R11 irq raised", 32'(irq), 32'h1);
    wrData = 8'h00; wrMask = 1; step(); wrMask = 0;
    check("R11 irq masked", 32'(irq), 32'h0);
    busWrCmd = 1; cmdBrkRst = 1; step(); busWrCmd = 0; cmdBrkRst = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1; step(); bitTick = 0; step();
    end
  endtask

  task automatic testTimeout();
    rxThreshold = 6'd4; rxLevel = 6'd2; rxEnable = 1; step();
    ticks(63);
    check("R8 no timeout at 63", 32'(statusOut[3]), 32'h0);
    ticks(1);
    check("R8 timeout at 64", 32'(statusOut[3]), 32'h1);
    rxCharIn = 1; rxLevel = 6'd3; step(); rxCharIn = 0;
    check("R9 arrival clears", 32'(statusOut[3]), 32'h0);
    ticks(63);
    check("R9 count restarted", 32'(statusOut[3]), 32'h0);
    ticks(1);
    check("R8 timeout again", 32'(statusOut[3]), 32'h1);
    rxLevel = 6'd0; step();
    check("R9 drained clears", 32'(statusOut[3]), 32'h0);
    rxLevel = 6'd4; step();
    ticks(70);
    check("R8 at threshold no timeout", 32'(statusOut[3]), 32'h0);
    rxLevel = 6'd1; step();
    ticks(64);
    check("R8 timeout below threshold", 32'(statusOut[3]), 32'h1);
    rxEnable = 0; step();
    check("R9 receiver off clears", 32'(statusOut[3]), 32'h0);
    rxEnable = 1; step();
    ticks(40);
    rxEnable = 0; step(); rxEnable = 1; step();
    ticks(63);
    check("R9 restart after disable", 32'(statusOut[3]), 32'h0);
    rxLevel = 0; step();
  endtask

  initial begin
    testReset();
    testLive();
    testTxLoad();
    testRxTxFifo();
    testSetWins();
    testBreakCos();
    testDivAutobaud();
    testMaskIrq();
    testTimeout();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule